// File: doc/BRIEF.md
# Dual-Bank Asynchronous Memory Controller

This block is a synchronous controller for an external memory module that carries a fast static RAM bank and a slower flash bank. Both banks share one 19-bit address bus and one 32-bit data bus. A host issues single-word read or write requests on a valid/ready port. A bank-select bit chooses static RAM (0) or flash (1), and a 4-bit byte-enable mask chooses the written lanes. The controller produces a separate active-low chip enable for each bank, one active-low output enable shared by both banks, and four active-low byte-lane write strobes per bank. Every phase length is counted in clock cycles.

Each timing value is a parameter given in nanoseconds. It is turned into cycles by rounding up at the clock period, with a floor of one cycle. The bank chosen for a request sets how long its access lasts. Flash writes are issued as plain bus cycles only. Command sequences and status polling are left to the host.

The data bus is brought out as a split output, an output-enable and an input. The pad ring builds the tri-state buffer from these.

Top module: `dbmc_top`

## Requirements
- R1: After reset, `req_ready` is 1, both chip enables, the output enable and all eight write strobes are high, `mem_dq_oe` is 0 and `rsp_valid` is 0.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the access and its recovery are over. `mem_addr` holds the taken address, unchanged, for as long as any chip enable is low.
- R3: Only the chip enable of the selected bank (`req_bank` 0 = static RAM, 1 = flash) goes low during an access. The two chip enables are never low together.
- R4: A read holds the selected chip enable and `mem_oe_n` low, with all write strobes high and `mem_dq_oe` 0, for exactly the read length. At the defaults this is 3 cycles for static RAM (25 ns) and 7 cycles for flash (70 ns).
- R5: `rsp_rdata` is the value on `mem_dq_i` in the last cycle that `mem_oe_n` is low. `rsp_valid` is 1 for exactly one cycle, the cycle right after that one. Writes give no response.
- R6: A write holds the selected chip enable low for one setup cycle plus the strobe length. The strobe length is 2 cycles for static RAM and 6 for flash at the defaults. `mem_oe_n` stays high throughout. `mem_dq_o` carries the write data, and `mem_dq_oe` is 1 in exactly those cycles.
- R7: During the strobe cycles, write strobe lane i of the selected bank is low only if byte-enable bit i is 1. Lane i covers data bits 8i+7..8i. The other bank's strobes stay high. A mask of 0 lowers no strobe.
- R8: After every access, both chip enables are high and `mem_dq_oe` is 0 for the recovery length (1 cycle at the default) before `req_ready` returns. `mem_oe_n` never falls in a cycle right after one with `mem_dq_oe` at 1.
- R9: Cycle counts are ceil(ns / CLK_NS), with a minimum of 1. The write strobe length is the largest of the rounded pulse width, the rounded data setup, and the rounded cycle time minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_bank | input | 1 | 0 selects static RAM, 1 selects flash |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 19 | Word address |
| req_be | input | 4 | Byte-lane enables for writes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle pulse when read data is ready |
| rsp_rdata | output | 32 | Read data |
| mem_addr | output | 19 | Address to the module |
| mem_dq_o | output | 32 | Data driven toward the module |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | 32 | Data returned from the module |
| mem_sram_ce_n | output | 1 | Static RAM chip enable, active low |
| mem_flash_ce_n | output | 1 | Flash chip enable, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| mem_sram_we_n | output | 4 | Static RAM byte-lane write strobes, active low |
| mem_flash_we_n | output | 4 | Flash byte-lane write strobes, active low |

## Verification
The pins are decoded from the phase register. They therefore change in the first cycle after the accepting edge, and the bench samples every cycle at the falling edge, from that first cycle until `req_ready` returns. Each request is measured by counting cycles, not by waiting for fixed delays. The bench counts low-chip-enable, low-output-enable, strobe, drive and recovery cycles, then compares them with lengths its own functions compute from the nanosecond parameters. The read response is due in the single cycle after the output enable rises. The bench therefore requires exactly one `rsp_valid` within the sampled window, and expects the word its memory model placed on the bus for that bank and address.

// File: rtl/dbmc_pkg.sv
package dbmc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RD,
    PH_WSU,
    PH_WST,
    PH_REC
  } phase_e;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

  // strobe phase: covers pulse width and data setup, and stretches the
  // whole write (one setup cycle plus strobe) to the bank cycle time
  function automatic int strobe_cyc(input int cyc_ns, input int wp_ns,
                                    input int ds_ns, input int clk_ns);
    return max3(ns_to_cyc(wp_ns, clk_ns), ns_to_cyc(ds_ns, clk_ns),
                ns_to_cyc(cyc_ns, clk_ns) - 1);
  endfunction

endpackage

// File: rtl/dbmc_req_latch.sv
module dbmc_req_latch #(
  parameter int AW    = 19,
  parameter int DW    = 32,
  parameter int LANES = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AW-1:0]    addr_in,
  input  logic [LANES-1:0] be_in,
  input  logic [DW-1:0]    wdata_in,
  output logic [AW-1:0]    addr_q,
  output logic [LANES-1:0] be_q,
  output logic [DW-1:0]    wdata_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
    end else if (load) begin
      addr_q  <= addr_in;
      be_q    <= be_in;
      wdata_q <= wdata_in;
    end
  end

endmodule

// File: rtl/dbmc_seq.sv
module dbmc_seq
  import dbmc_pkg::*;
#(
  parameter int RD_SR = 3,
  parameter int RD_FL = 7,
  parameter int WS_SR = 2,
  parameter int WS_FL = 6,
  parameter int REC   = 1,
  parameter int CW    = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   start_bank,
  input  logic   start_wr,
  output phase_e phase,
  output logic   bank_q,
  output logic   rd_done
);

  logic [CW-1:0] cnt;
  logic          cnt_zero;

  assign cnt_zero = (cnt == '0);
  assign rd_done  = (phase == PH_RD) && cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      bank_q <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          bank_q <= start_bank;
          if (start_wr) begin
            phase <= PH_WSU;
          end else begin
            phase <= PH_RD;
            cnt   <= start_bank ? CW'(RD_FL - 1) : CW'(RD_SR - 1);
          end
        end
        PH_RD: if (cnt_zero) begin
          phase <= PH_REC;
          cnt   <= CW'(REC - 1);
        end else begin
          cnt <= cnt - 1'b1;
        end
        PH_WSU: begin
          phase <= PH_WST;
          cnt   <= bank_q ? CW'(WS_FL - 1) : CW'(WS_SR - 1);
        end
        PH_WST: if (cnt_zero) begin
          phase <= PH_REC;
          cnt   <= CW'(REC - 1);
        end else begin
          cnt <= cnt - 1'b1;
        end
        PH_REC: if (cnt_zero) phase <= PH_IDLE;
                else cnt <= cnt - 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // the bank may change only when a new request is taken
  AST_BANK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |=> $stable(bank_q)); // R2

  // a strobe phase is always entered through the setup cycle
  AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WST && $past(phase) != PH_WST) |-> $past(phase) == PH_WSU); // R6

endmodule

// File: rtl/dbmc_pin_drv.sv
module dbmc_pin_drv
  import dbmc_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_e           phase,
  input  logic             bank_q,
  input  logic [LANES-1:0] be_q,
  output logic             sram_ce_n,
  output logic             flash_ce_n,
  output logic             oe_n,
  output logic             dq_oe,
  output logic [LANES-1:0] sram_we_n,
  output logic [LANES-1:0] flash_we_n
);

  logic active;
  logic strobe;

  assign active     = (phase == PH_RD) || (phase == PH_WSU) || (phase == PH_WST);
  assign strobe     = (phase == PH_WST);
  assign sram_ce_n  = !(active && !bank_q);
  assign flash_ce_n = !(active && bank_q);
  assign oe_n       = !(phase == PH_RD);
  assign dq_oe      = (phase == PH_WSU) || strobe;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign sram_we_n[i]  = !(strobe && !bank_q && be_q[i]);
    assign flash_we_n[i] = !(strobe && bank_q && be_q[i]);
  end

  AST_CE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    sram_ce_n || flash_ce_n); // R3

  AST_NO_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n); // R8

  AST_OE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> !$past(dq_oe)); // R8

  AST_WE_SRAM: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_we_n != '1) |-> (!sram_ce_n && dq_oe && oe_n && flash_we_n == '1)); // R7

  AST_WE_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_we_n != '1) |-> (!flash_ce_n && dq_oe && oe_n && sram_we_n == '1)); // R7

  AST_DATA_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(&(sram_we_n & flash_we_n)) |-> $past(dq_oe)); // R6

endmodule

// File: rtl/dbmc_top.sv
module dbmc_top
  import dbmc_pkg::*;
#(
  parameter int AW        = 19,
  parameter int DW        = 32,
  parameter int CLK_NS    = 10,
  parameter int SR_CYC_NS = 25,
  parameter int SR_WP_NS  = 17,
  parameter int SR_DS_NS  = 13,
  parameter int FL_CYC_NS = 70,
  parameter int FL_WP_NS  = 35,
  parameter int FL_DS_NS  = 30,
  parameter int REC_NS    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_bank,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [3:0]    req_be,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i,
  output logic          mem_sram_ce_n,
  output logic          mem_flash_ce_n,
  output logic          mem_oe_n,
  output logic [3:0]    mem_sram_we_n,
  output logic [3:0]    mem_flash_we_n
);

  localparam int LANES = DW / 8;
  localparam int RD_SR = ns_to_cyc(SR_CYC_NS, CLK_NS);
  localparam int RD_FL = ns_to_cyc(FL_CYC_NS, CLK_NS);
  localparam int WS_SR = strobe_cyc(SR_CYC_NS, SR_WP_NS, SR_DS_NS, CLK_NS);
  localparam int WS_FL = strobe_cyc(FL_CYC_NS, FL_WP_NS, FL_DS_NS, CLK_NS);
  localparam int REC   = ns_to_cyc(REC_NS, CLK_NS);
  localparam int MAXC  = max3(max3(RD_SR, RD_FL, WS_SR), WS_FL, REC);
  localparam int CW    = $clog2(MAXC + 1) + 1;

  phase_e           phase;
  logic             bank_q;
  logic             rd_done;
  logic             start;
  logic [LANES-1:0] be_q;
  logic             ce_any;

  assign req_ready = (phase == PH_IDLE);
  assign start     = req_valid && req_ready;

  dbmc_req_latch #(.AW(AW), .DW(DW), .LANES(LANES)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .addr_in  (req_addr),
    .be_in    (req_be[LANES-1:0]),
    .wdata_in (req_wdata),
    .addr_q   (mem_addr),
    .be_q     (be_q),
    .wdata_q  (mem_dq_o)
  );

  dbmc_seq #(
    .RD_SR(RD_SR), .RD_FL(RD_FL), .WS_SR(WS_SR), .WS_FL(WS_FL),
    .REC(REC), .CW(CW)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_bank (req_bank),
    .start_wr   (req_write),
    .phase      (phase),
    .bank_q     (bank_q),
    .rd_done    (rd_done)
  );

  dbmc_pin_drv #(.LANES(LANES)) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .bank_q     (bank_q),
    .be_q       (be_q),
    .sram_ce_n  (mem_sram_ce_n),
    .flash_ce_n (mem_flash_ce_n),
    .oe_n       (mem_oe_n),
    .dq_oe      (mem_dq_oe),
    .sram_we_n  (mem_sram_we_n),
    .flash_we_n (mem_flash_we_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_done;
      if (rd_done) rsp_rdata <= mem_dq_i;
    end
  end

  assign ce_any = !mem_sram_ce_n || !mem_flash_ce_n;

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_any && $past(ce_any)) |-> $stable(mem_addr)); // R2

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!ce_any && !mem_dq_oe)); // R8

  AST_RSP_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(!mem_oe_n) && mem_oe_n)); // R5

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R5

endmodule

// File: tb/dbmc_top_tb.sv
module dbmc_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_bank = 1'b0;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [18:0] mem_addr;
  logic [31:0] mem_dq_o;
  logic        mem_dq_oe;
  logic [31:0] mem_dq_i;
  logic        mem_sram_ce_n, mem_flash_ce_n, mem_oe_n;
  logic [3:0]  mem_sram_we_n, mem_flash_we_n;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dbmc_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_write(req_write), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i),
    .mem_sram_ce_n(mem_sram_ce_n), .mem_flash_ce_n(mem_flash_ce_n),
    .mem_oe_n(mem_oe_n), .mem_sram_we_n(mem_sram_we_n),
    .mem_flash_we_n(mem_flash_we_n)
  );

  // memory model: each bank answers with its own address-derived word
  function automatic logic [31:0] pat(input logic [18:0] a, input logic b);
    return b ? ({a[15:0], 16'hF1A5} ^ 32'h0F0F_0000) : {13'h0A5, a};
  endfunction

  assign mem_dq_i = (!mem_oe_n && !mem_sram_ce_n)  ? pat(mem_addr, 1'b0) :
                    (!mem_oe_n && !mem_flash_ce_n) ? pat(mem_addr, 1'b1) :
                    32'h0;

  // timing expectations restated from the requirements (10 ns clock)
  function automatic int cyc(input int ns);
    int c;
    c = ns / 10;
    if (c * 10 < ns) c = c + 1;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int exp_rd(input logic b);
    return b ? cyc(70) : cyc(25);
  endfunction

  function automatic int exp_ws(input logic b);
    int w;
    w = b ? cyc(35) : cyc(17);
    if ((b ? cyc(30) : cyc(13)) > w) w = b ? cyc(30) : cyc(13);
    if ((b ? cyc(70) : cyc(25)) - 1 > w) w = (b ? cyc(70) : cyc(25)) - 1;
    return w;
  endfunction

  localparam int EXP_REC = 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_req(input logic b, input logic wr, input logic [18:0] a,
                         input logic [3:0] be, input logic [31:0] wd);
    int n_ce = 0, n_oe = 0, n_we = 0, n_dq = 0, n_rec = 0, n_rsp = 0, k = 0;
    bit bad_addr = 0, bad_ce = 0, bad_mask = 0, bad_data = 0, bad_fight = 0;
    bit prev_dq = 0;
    logic [31:0] got = 0;
    logic [3:0] exp_mask;
    @(negedge clk);
    req_valid = 1'b1; req_bank = b; req_write = wr; req_addr = a;
    req_be = be; req_wdata = wd;
    check(req_ready == 1'b1, "R2", "ready before request", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr = ~a; req_bank = ~b; req_wdata = ~wd;
    while (!req_ready && k < 100) begin
      k++;
      if (!mem_sram_ce_n || !mem_flash_ce_n) begin
        if (mem_addr != a) bad_addr = 1;
        if ((b ? mem_sram_ce_n : mem_flash_ce_n) == 1'b0) bad_ce = 1;
        n_ce++;
      end else begin
        if (!mem_dq_oe) n_rec++;
      end
      if (!mem_oe_n) n_oe++;
      if (mem_dq_oe) begin
        n_dq++;
        if (mem_dq_o != wd) bad_data = 1;
      end
      if ((mem_sram_we_n & mem_flash_we_n) != 4'hF) begin
        n_we++;
        exp_mask = ~be;
        if ((b ? mem_flash_we_n : mem_sram_we_n) != exp_mask) bad_mask = 1;
        if ((b ? mem_sram_we_n : mem_flash_we_n) != 4'hF) bad_mask = 1;
      end
      if (!mem_oe_n && prev_dq) bad_fight = 1;
      if (rsp_valid) begin n_rsp++; got = rsp_rdata; end
      prev_dq = mem_dq_oe;
      @(negedge clk);
    end
    check(k < 100, "R2", "ready returns", k, 100);
    check(!bad_addr, "R2", "address held", 0, a);
    check(!bad_ce, "R3", "only selected chip enable", b, b);
    check(n_rec == EXP_REC, "R8", "recovery cycles", n_rec, EXP_REC);
    check(!bad_fight, "R8", "bus released before output enable", 1, 0);
    if (!wr) begin
      check(n_ce == exp_rd(b) && n_oe == exp_rd(b), "R4", "read length",
            n_oe, exp_rd(b));
      check(n_we == 0 && n_dq == 0, "R4", "no drive during read", n_dq, 0);
      check(n_rsp == 1, "R5", "one response", n_rsp, 1);
      check(got == pat(a, b), "R5", "read data", got, pat(a, b));
    end else begin
      check(n_ce == 1 + exp_ws(b), "R6", "write length", n_ce, 1 + exp_ws(b));
      check(n_dq == 1 + exp_ws(b) && !bad_data, "R6", "write drive", n_dq,
            1 + exp_ws(b));
      check(n_oe == 0 && n_rsp == 0, "R6", "no oe or response on write",
            n_oe, 0);
      check(!bad_mask, "R7", "lane strobes", be, be);
      check(n_we == ((be == 0) ? 0 : exp_ws(b)), "R7", "strobe cycles", n_we,
            (be == 0) ? 0 : exp_ws(b));
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4321));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(req_ready && mem_sram_ce_n && mem_flash_ce_n && mem_oe_n &&
          mem_sram_we_n == 4'hF && mem_flash_we_n == 4'hF && !mem_dq_oe &&
          !rsp_valid, "R1", "reset pins", 0, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && mem_sram_ce_n && mem_flash_ce_n, "R1",
          "idle after reset", req_ready, 1);
    // R9 cycle counts at the defaults
    check(exp_rd(0) == 3 && exp_rd(1) == 7 && exp_ws(0) == 2 && exp_ws(1) == 6,
          "R9", "rounded lengths", exp_ws(1), 6);
    // directed corners
    run_req(1'b0, 1'b0, 19'h00000, 4'hF, 32'h0);
    run_req(1'b1, 1'b0, 19'h7FFFF, 4'hF, 32'h0);
    run_req(1'b0, 1'b1, 19'h12345, 4'hF, 32'hDEAD_BEEF);
    run_req(1'b0, 1'b0, 19'h12345, 4'h0, 32'h0);
    run_req(1'b1, 1'b1, 19'h00001, 4'h0, 32'h1111_2222);
    run_req(1'b1, 1'b1, 19'h40000, 4'b0101, 32'hCAFE_F00D);
    run_req(1'b1, 1'b0, 19'h40000, 4'hF, 32'h0);
    run_req(1'b0, 1'b1, 19'h00010, 4'b1000, 32'h8000_0001);
    // random mix
    for (int i = 0; i < 60; i++) begin
      run_req(1'($urandom), 1'($urandom), 19'($urandom), 4'($urandom),
              $urandom);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule